// File: doc/BRIEF.md
# Closed-Loop Linearity Calibration Controller

This block runs a closed-loop linearity calibration of an amplifier whose linearity can be trimmed digitally through a 3-bit tuning code. After a start pulse it sweeps every tuning code, from 0 upward. For each code it drives the code, waits a programmable number of settling cycles and issues a measurement request. It then takes back a third-order intermodulation (IM3) figure from a spectral measurement engine, which analyses the response to a two-tone stimulus. The amplifier and detector test conditions stay the same for every code, so any error the detector adds is common to all codes and drops out of the comparisons. The controller keeps the code whose IM3 figure was lowest, drives that code onto the tuning pins at the end and raises done.

The measurement request and the result return each use a valid/ready handshake. A request stays valid, with the tuning code frozen, until the engine accepts it. The controller raises ready for the result only after its request has been accepted. It then holds ready until a result arrives and ignores the result bus at all other times. Start, done, the settle count and the best code are plain level pins. Pulsing start again after done reruns the sweep, so the amplifier can be recalibrated periodically over its lifetime. A start pulse during a sweep is ignored.

Top module: `lincal_ctrl`

## Requirements
- R1: One sweep applies the tuning codes in ascending order 0,1,...,7, issuing exactly one measurement request per code, and exactly 8 requests per sweep.
- R2: The selected code is the one whose IM3 value, treated as an unsigned number where smaller means more linear, is the lowest of the sweep.
- R3: If IM3 values are equal, the lower-numbered code is kept, because only a strictly smaller value replaces the stored best.
- R4: The request valid rises exactly settle_cycles_i + 2 clock cycles after the tuning code changes to a new value, for any settle count including 0.
- R5: While a request is valid and not accepted, request valid stays high. The tuning code stays unchanged from the request until its result is accepted.
- R6: Result ready is low while a request is outstanding, and rises in the cycle after the request handshake. A result offered while ready is low is ignored.
- R7: After the eighth result, done_o rises, best_code_o shows the selected code and tune_code_o is driven with it. done_o and the tuning code hold until the next start.
- R8: A start pulse during a sweep has no effect. A start pulse while done is high clears done in the next cycle and begins a new sweep at code 0.
- R9: After reset the tuning code and best code are 0, and done, request valid and result ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Starts a sweep when idle or done |
| settle_cycles_i | input | SETTLE_W | Settling wait after each code change |
| tune_code_o | output | CODE_W | Tuning code driven to the amplifier |
| meas_req_valid_o | output | 1 | Measurement request valid |
| meas_req_ready_i | input | 1 | Measurement engine accepts the request |
| im3_valid_i | input | 1 | IM3 result valid |
| im3_ready_o | output | 1 | Controller accepts the IM3 result |
| im3_value_i | input | IM3_W | IM3 figure, unsigned, lower is better |
| done_o | output | 1 | Calibration finished, best code applied |
| best_code_o | output | CODE_W | Code selected by the last sweep |

## Verification
The hardest state to reach is a measurement where both handshakes are under back-pressure: a request that waits several cycles for acceptance while a decoy result of value 0 sits on the result bus. The stimulus holds request ready low for a number of cycles that changes from code to code. During that wait it drives a zero result that would win the comparison if it were taken. After each sweep the bench checks that the selected code is still the expected one. Ties, a minimum at the first or the last code, and a start pulse during a measurement come from the vector table and one directed sweep.

// File: rtl/lincal_pkg.sv
package lincal_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_APPLY   = 3'd1,
    ST_SETTLE  = 3'd2,
    ST_MEASURE = 3'd3,
    ST_COMPARE = 3'd4,
    ST_FINISH  = 3'd5
  } cal_state_e;
endpackage

// File: rtl/lincal_settle_timer.sv
module lincal_settle_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/lincal_meas_port.sv
module lincal_meas_port #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  input  logic              res_valid_i,
  output logic              res_ready_o,
  input  logic [DATA_W-1:0] res_data_i,
  output logic              res_fire_o,
  output logic [DATA_W-1:0] res_data_o
);
  logic              sent_q;
  logic [DATA_W-1:0] data_q;

  assign req_valid_o = active_i && !sent_q;
  assign res_ready_o = active_i && sent_q;
  assign res_fire_o  = res_ready_o && res_valid_i;
  assign res_data_o  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sent_q <= 1'b0;
    end else if (!active_i) begin
      sent_q <= 1'b0;
    end else if (req_valid_o && req_ready_i) begin
      sent_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (res_fire_o) begin
      data_q <= res_data_i;
    end
  end
endmodule

// File: rtl/lincal_best_track.sv
module lincal_best_track #(
  parameter int CODE_W = 3,
  parameter int VAL_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              cand_en_i,
  input  logic [CODE_W-1:0] cand_code_i,
  input  logic [VAL_W-1:0]  cand_val_i,
  output logic              take_o,
  output logic [CODE_W-1:0] best_code_o
);
  logic              have_q;
  logic [VAL_W-1:0]  best_val_q;
  logic [CODE_W-1:0] best_code_q;

  // strict less-than: an equal later value never displaces the earlier code
  assign take_o      = !have_q || (cand_val_i < best_val_q);
  assign best_code_o = best_code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q      <= 1'b0;
      best_val_q  <= '0;
      best_code_q <= '0;
    end else if (clear_i) begin
      have_q      <= 1'b0;
    end else if (cand_en_i && take_o) begin
      have_q      <= 1'b1;
      best_val_q  <= cand_val_i;
      best_code_q <= cand_code_i;
    end
  end
endmodule

// File: rtl/lincal_ctrl.sv
module lincal_ctrl #(
  parameter int CODE_W   = 3,
  parameter int IM3_W    = 16,
  parameter int SETTLE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [SETTLE_W-1:0] settle_cycles_i,
  output logic [CODE_W-1:0]   tune_code_o,
  output logic                meas_req_valid_o,
  input  logic                meas_req_ready_i,
  input  logic                im3_valid_i,
  output logic                im3_ready_o,
  input  logic [IM3_W-1:0]    im3_value_i,
  output logic                done_o,
  output logic [CODE_W-1:0]   best_code_o
);
  import lincal_pkg::*;

  localparam logic [CODE_W-1:0] LAST_CODE = '1;

  cal_state_e        state_q, state_d;
  logic [CODE_W-1:0] code_q;
  logic              launch;
  logic              settle_done;
  logic              res_fire;
  logic [IM3_W-1:0]  res_val;
  logic              take;
  logic [CODE_W-1:0] best_code;

  assign launch = start_i && (state_q == ST_IDLE || state_q == ST_FINISH);

  lincal_settle_timer #(.W(SETTLE_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (state_q == ST_APPLY),
    .load_val_i (settle_cycles_i),
    .run_i      (state_q == ST_SETTLE),
    .expired_o  (settle_done)
  );

  lincal_meas_port #(.DATA_W(IM3_W)) u_meas (
    .clk         (clk),
    .rst_n       (rst_n),
    .active_i    (state_q == ST_MEASURE),
    .req_valid_o (meas_req_valid_o),
    .req_ready_i (meas_req_ready_i),
    .res_valid_i (im3_valid_i),
    .res_ready_o (im3_ready_o),
    .res_data_i  (im3_value_i),
    .res_fire_o  (res_fire),
    .res_data_o  (res_val)
  );

  lincal_best_track #(.CODE_W(CODE_W), .VAL_W(IM3_W)) u_best (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (launch),
    .cand_en_i   (state_q == ST_COMPARE),
    .cand_code_i (code_q),
    .cand_val_i  (res_val),
    .take_o      (take),
    .best_code_o (best_code)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (launch) state_d = ST_APPLY;
      ST_APPLY:   state_d = ST_SETTLE;
      ST_SETTLE:  if (settle_done) state_d = ST_MEASURE;
      ST_MEASURE: if (res_fire) state_d = ST_COMPARE;
      ST_COMPARE: state_d = (code_q == LAST_CODE) ? ST_FINISH : ST_APPLY;
      ST_FINISH:  if (launch) state_d = ST_APPLY;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
    end else begin
      state_q <= state_d;
      if (launch) begin
        code_q <= '0;
      end else if (state_q == ST_COMPARE) begin
        if (code_q != LAST_CODE) code_q <= code_q + 1'b1;
        else                     code_q <= take ? code_q : best_code;
      end
    end
  end

  assign tune_code_o = code_q;
  assign done_o      = (state_q == ST_FINISH);
  assign best_code_o = best_code;
endmodule

// File: rtl/lincal_ctrl_chk.sv
module lincal_ctrl_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [CODE_W-1:0] tune_code_o,
  input logic              meas_req_valid_o,
  input logic              meas_req_ready_i,
  input logic              im3_valid_i,
  input logic              im3_ready_o,
  input logic              done_o,
  input logic [CODE_W-1:0] best_code_o
);
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    meas_req_valid_o && !meas_req_ready_i |=> meas_req_valid_o && $stable(tune_code_o));

  a_r5_code_frozen_wait: assert property (@(posedge clk) disable iff (!rst_n)
    im3_ready_o && !im3_valid_i |=> $stable(tune_code_o));

  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(meas_req_valid_o && im3_ready_o));

  a_r6_ready_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(im3_ready_o) |-> $past(meas_req_valid_o && meas_req_ready_i));

  a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o && $stable(tune_code_o));

  a_r7_done_code: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> tune_code_o == best_code_o);

  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !meas_req_valid_o && !im3_ready_o);
endmodule

bind lincal_ctrl lincal_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .start_i          (start_i),
  .tune_code_o      (tune_code_o),
  .meas_req_valid_o (meas_req_valid_o),
  .meas_req_ready_i (meas_req_ready_i),
  .im3_valid_i      (im3_valid_i),
  .im3_ready_o      (im3_ready_o),
  .done_o           (done_o),
  .best_code_o      (best_code_o)
);

// File: tb/lincal_ctrl_bench.sv
`timescale 1ns/1ps
module lincal_ctrl_bench;
  localparam int NV = 6;
  localparam logic [15:0] VEC [NV][8] = '{
    '{16'd500, 16'd400, 16'd300, 16'd200, 16'd100, 16'd150, 16'd250, 16'd350},
    '{16'd10,  16'd20,  16'd30,  16'd40,  16'd50,  16'd60,  16'd70,  16'd80},
    '{16'd90,  16'd80,  16'd70,  16'd60,  16'd50,  16'd40,  16'd30,  16'd20},
    '{16'd300, 16'd100, 16'd200, 16'd100, 16'd400, 16'd100, 16'd500, 16'd600},
    '{16'd777, 16'd777, 16'd777, 16'd777, 16'd777, 16'd777, 16'd777, 16'd777},
    '{16'hFFFF, 16'hFFFF, 16'h0001, 16'h0001, 16'hFFFF, 16'h8000, 16'h7FFF, 16'hFFFE}
  };
  localparam int EXP [NV] = '{4, 0, 7, 1, 0, 2};
  localparam int SET [NV] = '{0, 3, 1, 7, 2, 5};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] settle = '0;
  logic [2:0]  tune;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [15:0] res_val = '0;
  logic        done;
  logic [2:0]  best;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int age = 0;
  logic [2:0] last_code = '0;

  always #2.5 clk = ~clk;

  lincal_ctrl u_lincal_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start), .settle_cycles_i(settle),
    .tune_code_o(tune), .meas_req_valid_o(req_valid), .meas_req_ready_i(req_ready),
    .im3_valid_i(res_valid), .im3_ready_o(res_ready), .im3_value_i(res_val),
    .done_o(done), .best_code_o(best)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 60000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 60000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (tune !== last_code) begin
      last_code = tune;
      age = 0;
    end else begin
      age++;
    end
  endtask

  task automatic run_sweep(input int idx, input bit poke_start);
    settle = 12'(SET[idx]);
    start = 1'b1;
    step();
    start = 1'b0;
    chk("R8 start clears done", int'(done), 0);
    for (int i = 0; i < 8; i++) begin
      while (!req_valid) step();
      chk("R1 code order", int'(tune), i);
      if (i > 0) chk("R4 settle spacing", age, SET[idx] + 2);
      // back-pressure on the request with a decoy zero result (R6)
      res_valid = 1'b1;
      res_val = 16'd0;
      for (int d = 0; d < (i % 3) + 1; d++) begin
        if (poke_start && i == 4 && d == 0) start = 1'b1;
        step();
        start = 1'b0;
        chk("R5 req held", int'(req_valid), 1);
        chk("R6 no ready before accept", int'(res_ready), 0);
      end
      res_valid = 1'b0;
      req_ready = 1'b1;
      step();
      req_ready = 1'b0;
      chk("R6 ready after accept", int'(res_ready), 1);
      for (int r = 0; r < (i % 2) + 1; r++) step();
      chk("R5 code frozen", int'(tune), i);
      res_val = VEC[idx][i];
      res_valid = 1'b1;
      step();
      res_valid = 1'b0;
    end
    for (int w = 0; w < 6 && !done; w++) begin
      step();
      if (req_valid) chk("R1 no ninth request", 1, 0);
    end
    chk("R7 done", int'(done), 1);
    chk("R2 R3 best code", int'(best), EXP[idx]);
    chk("R7 tune drives best", int'(tune), EXP[idx]);
    for (int h = 0; h < 10; h++) step();
    chk("R7 done held", int'(done), 1);
    chk("R7 tune held", int'(tune), EXP[idx]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset tune", int'(tune), 0);
    chk("R9 reset done", int'(done), 0);
    chk("R9 reset req", int'(req_valid), 0);
    chk("R9 reset ready", int'(res_ready), 0);
    chk("R9 reset best", int'(best), 0);
    rst_n = 1'b1;
    step();
    step();
    chk("R8 idle without start", int'(req_valid), 0);

    for (int v = 0; v < NV; v++) run_sweep(v, 1'b0);

    // directed: start pulse during a measurement is ignored (R8)
    run_sweep(3, 1'b1);

    // directed: reset in the middle of a sweep
    settle = 12'd2;
    start = 1'b1;
    step();
    start = 1'b0;
    while (!req_valid) step();
    rst_n = 1'b0;
    step();
    chk("R9 mid-sweep reset req", int'(req_valid), 0);
    chk("R9 mid-sweep reset done", int'(done), 0);
    chk("R9 mid-sweep reset tune", int'(tune), 0);
    rst_n = 1'b1;
    step();
    run_sweep(0, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule